// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

The block manages a bank of general-purpose pins behind a small memory-mapped register bus with 32-bit data and word-aligned byte offsets. Software drives pins through an output value register, which it can overwrite whole or change bit by bit through write-one set and clear ports. A per-pin drive-enable register decides which pins the block drives. Pad levels come back through a two-flop synchronizer and can be read at any time.

Each pin can be set to raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. Three per-pin bits choose the trigger: a kind bit (edge or level), a polarity bit and an any-edge bit. A detected edge is held in a sticky pending bit until software acknowledges it. A level trigger follows the synchronized pad directly. Status reads show the pending conditions of the enabled pins. A single interrupt output is the OR of all status bits that are not hidden by the per-pin mask. Pull and input-filter settings are kept as plain read/write storage for the pad ring.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, pad_oe is 0 on all pins and irq_out is 0.
- R2: A write to offset 0x00 loads the output value. A write to 0x10 sets every output bit written as 1, and a write to 0x14 clears every output bit written as 1. Bits written as 0 keep their value. pad_out always shows the output value.
- R3: Offset 0x08 holds drive-enable bits. A 1 makes the pin an output, and pad_oe shows the register.
- R4: Offset 0x04 returns the pad levels through a two-flop synchronizer. A pad change is visible in a read taken after the second rising clock edge, and not in a read taken after the first.
- R5: A kind bit (offset 0x34) of 1 selects level triggering. With the polarity bit (offset 0x3C) at 0 the pin is active while its synchronized input is high, and with it at 1 while the input is low. Level status follows the input, and a write to the acknowledge register does not clear it.
- R6: A kind bit of 0 selects edge triggering. With the any-edge bit (offset 0x38) at 0, polarity 0 triggers on a rising edge and polarity 1 on a falling edge. A detected edge sets a pending bit that stays set until it is acknowledged.
- R7: In edge mode with the any-edge bit at 1, both rising and falling edges set the pending bit.
- R8: Writing a 1 to a bit of the acknowledge register (offset 0x30) clears that pin's pending edge, and other pins are unaffected. If an edge is detected in the same cycle as the acknowledge, the bit stays set.
- R9: Status (offset 0x24) reads the pending bits ANDed with the enable register (offset 0x20). A pending edge that is captured while the pin is disabled appears once the pin is enabled.
- R10: irq_out is 1 exactly when some status bit is set whose mask bit (offset 0x2C) is 0. Masking does not change the status read.
- R11: Offsets 0x18, 0x1C and 0x40 (per-pin bits) and 0x44 (32 bits) read back what was last written.
- R12: Reads of unused offsets, of the write-only offsets 0x10, 0x14 and 0x30, and of addresses that are not word-aligned return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read |
| pad_in | input | NPIN | Asynchronous pad levels |
| pad_out | output | NPIN | Output value for the pads |
| pad_oe | output | NPIN | Per-pin drive enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that a write is a single-cycle strobe whose address and data are stable at the sampling edge, and that pad_in changes are at least one cycle apart for any one pin, so every transition passes through the synchronizer as one clean edge. The stimulus drives the bus and the pads only on the falling clock edge and holds each pad pattern for several cycles before changing it. The same-cycle acknowledge case is placed by counting two rising edges after a pad change, so that the acknowledge write lands exactly on the cycle in which the edge is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // word indices (byte offset / 4) of the register map
   localparam int W_OUTVAL   = 0;   // 0x00
   localparam int W_INVAL    = 1;   // 0x04
   localparam int W_DRIVE    = 2;   // 0x08
   localparam int W_OUTSET   = 4;   // 0x10
   localparam int W_OUTCLR   = 5;   // 0x14
   localparam int W_PULLON   = 6;   // 0x18
   localparam int W_PULLSEL  = 7;   // 0x1C
   localparam int W_IRQON    = 8;   // 0x20
   localparam int W_IRQFLAG  = 9;   // 0x24
   localparam int W_IRQHIDE  = 11;  // 0x2C
   localparam int W_IRQACK   = 12;  // 0x30
   localparam int W_TRGKIND  = 13;  // 0x34
   localparam int W_TRGANY   = 14;  // 0x38
   localparam int W_TRGPOL   = 15;  // 0x3C
   localparam int W_FILTON   = 16;  // 0x40
   localparam int W_FILTDIV  = 17;  // 0x44

   typedef enum logic [4:0] {
      RS_NONE,
      RS_OUTVAL, RS_INVAL, RS_DRIVE, RS_OUTSET, RS_OUTCLR,
      RS_PULLON, RS_PULLSEL,
      RS_IRQON, RS_IRQFLAG, RS_IRQHIDE, RS_IRQACK,
      RS_TRGKIND, RS_TRGANY, RS_TRGPOL,
      RS_FILTON, RS_FILTDIV
   } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NPIN        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pad_i,
   output logic [NPIN-1:0] sync_o
);

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("gpio_in_sync: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0] stg_q [SYNC_STAGES];

   for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= pad_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_q[k-1];
         end
      end
   end

   assign sync_o = stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] sync_i,
   input  logic [NPIN-1:0] kind_i,   // 1 = level, 0 = edge
   input  logic [NPIN-1:0] pol_i,    // level: 1 = active low; edge: 1 = falling
   input  logic [NPIN-1:0] any_i,    // edge: 1 = both directions
   input  logic [NPIN-1:0] en_i,
   input  logic [NPIN-1:0] ack_i,    // one-cycle acknowledge pulses
   output logic [NPIN-1:0] status_o
);

   logic [NPIN-1:0] prev_q;
   logic [NPIN-1:0] pend_q;
   logic [NPIN-1:0] hit;
   logic [NPIN-1:0] raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic rise, fall, lvl_act;
      always_comb begin
         rise    = sync_i[i] & ~prev_q[i];
         fall    = ~sync_i[i] & prev_q[i];
         hit[i]  = ~kind_i[i] & (any_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise));
         lvl_act = sync_i[i] ^ pol_i[i];
         raw[i]  = kind_i[i] ? lvl_act : pend_q[i];
      end
   end

   // a new edge outranks an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack_i) | hit;
   end

   assign status_o = raw & en_i;

   a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(ack_i & ~hit)) == '0))
      else $error("R8: acknowledged pending bit survived");

   a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)))
      else $error("R8: detected edge not latched");

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~ack_i)) == $past(pend_q & ~ack_i)))
      else $error("R6: pending bit lost without acknowledge");

endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPIN-1:0]   din_i,
   input  logic [NPIN-1:0]   status_i,
   output logic [NPIN-1:0]   outval_o,
   output logic [NPIN-1:0]   drive_o,
   output logic [NPIN-1:0]   irqon_o,
   output logic [NPIN-1:0]   irqhide_o,
   output logic [NPIN-1:0]   kind_o,
   output logic [NPIN-1:0]   pol_o,
   output logic [NPIN-1:0]   any_o,
   output logic [NPIN-1:0]   ack_o
);

   localparam int WIDX = ADDR_W - 2;

   logic [NPIN-1:0] outval_q, drive_q, pullon_q, pullsel_q;
   logic [NPIN-1:0] irqon_q, irqhide_q, kind_q, any_q, pol_q, filton_q;
   logic [31:0]     filtdiv_q;
   logic [NPIN-1:0] wd;
   logic [WIDX-1:0] widx;
   reg_sel_e        rsel;
   logic            wr_go;

   assign wd    = bus_wdata[NPIN-1:0];
   assign widx  = bus_addr[ADDR_W-1:2];
   assign wr_go = bus_sel & bus_wr;

   always_comb begin
      rsel = RS_NONE;
      if (bus_addr[1:0] == 2'b00) begin
         case (int'(widx))
            W_OUTVAL:  rsel = RS_OUTVAL;
            W_INVAL:   rsel = RS_INVAL;
            W_DRIVE:   rsel = RS_DRIVE;
            W_OUTSET:  rsel = RS_OUTSET;
            W_OUTCLR:  rsel = RS_OUTCLR;
            W_PULLON:  rsel = RS_PULLON;
            W_PULLSEL: rsel = RS_PULLSEL;
            W_IRQON:   rsel = RS_IRQON;
            W_IRQFLAG: rsel = RS_IRQFLAG;
            W_IRQHIDE: rsel = RS_IRQHIDE;
            W_IRQACK:  rsel = RS_IRQACK;
            W_TRGKIND: rsel = RS_TRGKIND;
            W_TRGANY:  rsel = RS_TRGANY;
            W_TRGPOL:  rsel = RS_TRGPOL;
            W_FILTON:  rsel = RS_FILTON;
            W_FILTDIV: rsel = RS_FILTDIV;
            default:   rsel = RS_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outval_q  <= '0;
         drive_q   <= '0;
         pullon_q  <= '0;
         pullsel_q <= '0;
         irqon_q   <= '0;
         irqhide_q <= '0;
         kind_q    <= '0;
         any_q     <= '0;
         pol_q     <= '0;
         filton_q  <= '0;
         filtdiv_q <= '0;
      end else if (wr_go) begin
         case (rsel)
            RS_OUTVAL:  outval_q  <= wd;
            RS_OUTSET:  outval_q  <= outval_q | wd;
            RS_OUTCLR:  outval_q  <= outval_q & ~wd;
            RS_DRIVE:   drive_q   <= wd;
            RS_PULLON:  pullon_q  <= wd;
            RS_PULLSEL: pullsel_q <= wd;
            RS_IRQON:   irqon_q   <= wd;
            RS_IRQHIDE: irqhide_q <= wd;
            RS_TRGKIND: kind_q    <= wd;
            RS_TRGANY:  any_q     <= wd;
            RS_TRGPOL:  pol_q     <= wd;
            RS_FILTON:  filton_q  <= wd;
            RS_FILTDIV: filtdiv_q <= bus_wdata;
            default:    ;
         endcase
      end
   end

   assign ack_o = (wr_go && rsel == RS_IRQACK) ? wd : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (rsel)
            RS_OUTVAL:  bus_rdata = 32'(outval_q);
            RS_INVAL:   bus_rdata = 32'(din_i);
            RS_DRIVE:   bus_rdata = 32'(drive_q);
            RS_PULLON:  bus_rdata = 32'(pullon_q);
            RS_PULLSEL: bus_rdata = 32'(pullsel_q);
            RS_IRQON:   bus_rdata = 32'(irqon_q);
            RS_IRQFLAG: bus_rdata = 32'(status_i);
            RS_IRQHIDE: bus_rdata = 32'(irqhide_q);
            RS_TRGKIND: bus_rdata = 32'(kind_q);
            RS_TRGANY:  bus_rdata = 32'(any_q);
            RS_TRGPOL:  bus_rdata = 32'(pol_q);
            RS_FILTON:  bus_rdata = 32'(filton_q);
            RS_FILTDIV: bus_rdata = filtdiv_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign outval_o  = outval_q;
   assign drive_o   = drive_q;
   assign irqon_o   = irqon_q;
   assign irqhide_o = irqhide_q;
   assign kind_o    = kind_q;
   assign pol_o     = pol_q;
   assign any_o     = any_q;

   a_r2_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && rsel == RS_OUTSET) |=> (outval_q == ($past(outval_q) | $past(wd))))
      else $error("R2: set port did not OR in written ones");

   a_r2_clr_ands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && rsel == RS_OUTCLR) |=> (outval_q == ($past(outval_q) & ~$past(wd))))
      else $error("R2: clear port did not drop written ones");

   a_r12_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && (rsel == RS_NONE || rsel == RS_INVAL || rsel == RS_IRQFLAG)) |=> $stable(outval_q))
      else $error("R12: write to a read-only or unused slot changed the output value");

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int NPIN        = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic              irq_out
);

   initial begin : p_param_chk
      assert (NPIN >= 1 && NPIN <= 32) else $error("gpio_irq_ctrl: NPIN must be 1..32");
      assert (ADDR_W >= 7) else $error("gpio_irq_ctrl: ADDR_W too small for the register map");
   end

   logic [NPIN-1:0] sync_in, status, irqon, irqhide, kind, pol, any_edge, ack;

   gpio_in_sync #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pad_in),
      .sync_o (sync_in)
   );

   gpio_bus_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .din_i     (sync_in),
      .status_i  (status),
      .outval_o  (pad_out),
      .drive_o   (pad_oe),
      .irqon_o   (irqon),
      .irqhide_o (irqhide),
      .kind_o    (kind),
      .pol_o     (pol),
      .any_o     (any_edge),
      .ack_o     (ack)
   );

   gpio_trig #(.NPIN(NPIN)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_in),
      .kind_i   (kind),
      .pol_i    (pol),
      .any_i    (any_edge),
      .en_i     (irqon),
      .ack_i    (ack),
      .status_o (status)
   );

   assign irq_out = |(status & ~irqhide);

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((irqon | irqhide) == '1 && irqhide == '1) |-> !irq_out)
      else $error("R10: irq_out raised with every pin masked");

   a_r5_level_live: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind & irqon) == '1) |-> (status == (sync_in ^ pol)))
      else $error("R5: level status does not track the synchronized input");

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

   typedef struct packed {
      logic [31:0] kind;
      logic [31:0] pol;
      logic [31:0] any;
      logic [31:0] pa;
      logic [31:0] pb;
      logic [31:0] exp;
   } vec_t;

   // trigger vectors: config, first pad pattern, second pad pattern, expected status
   localparam vec_t VT [7] = '{
      '{32'h0, 32'h0,        32'h0,        32'h0,        32'h0000FFFF, 32'h0000FFFF}, // R6 rising
      '{32'h0, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'hFFFF0000, 32'h0000FFFF}, // R6 falling
      '{32'h0, 32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0},        // R6 rising ignores falls
      '{32'h0, 32'h0,        32'hFFFFFFFF, 32'h00FF00FF, 32'hFF0000FF, 32'hFFFF0000}, // R7 any edge
      '{32'hFFFFFFFF, 32'h0, 32'h0,        32'h0,        32'h12345678, 32'h12345678}, // R5 high
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0,        32'h12345678, 32'hEDCBA987}, // R5 low
      '{32'hFFFF0000, 32'hFF00FF00, 32'h000000F0, 32'h0F0F0F0F, 32'h33333333, 32'hCC330C30} // R5/R6/R7 mixed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] pad = '0;
   logic [31:0] rdata, pout, poe;
   logic        irq;
   int          total = 0;
   int          bad = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   gpio_irq_ctrl #(.NPIN(32), .ADDR_W(8), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad), .pad_out(pout),
      .pad_oe(poe), .irq_out(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rreg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic setpad(input logic [31:0] v);
      @(negedge clk);
      pad = v;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      begin
         logic [7:0] ro [12] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20,
                                 8'h24, 8'h2C, 8'h34, 8'h38, 8'h3C, 8'h44};
         for (int i = 0; i < 12; i++) begin
            rreg(ro[i], rv);
            chk($sformatf("R1 reset reg %h", ro[i]), rv, 32'h0);
         end
         rreg(8'h40, rv);
         chk("R1 reset filter enable", rv, 32'h0);
         chk("R1 pad_oe", poe, 32'h0);
         chk("R1 irq_out", {31'h0, irq}, 32'h0);
      end

      // R2: output value, set and clear ports
      wreg(8'h00, 32'hA5A5A5A5);
      rreg(8'h00, rv);
      chk("R2 load", rv, 32'hA5A5A5A5);
      wreg(8'h10, 32'h0000000F);
      rreg(8'h00, rv);
      chk("R2 set", rv, 32'hA5A5A5AF);
      wreg(8'h14, 32'hA0000001);
      rreg(8'h00, rv);
      chk("R2 clear", rv, 32'h05A5A5AE);
      chk("R2 pad_out", pout, 32'h05A5A5AE);

      // R3: drive enable
      wreg(8'h08, 32'h0F0F0000);
      chk("R3 pad_oe", poe, 32'h0F0F0000);
      rreg(8'h08, rv);
      chk("R3 readback", rv, 32'h0F0F0000);

      // R4: synchronizer latency
      setpad(32'hCAFEBABE);
      rreg(8'h04, rv);
      chk("R4 after one edge", rv, 32'h0);
      rreg(8'h04, rv);
      chk("R4 after two edges", rv, 32'hCAFEBABE);

      // R11: plain storage
      wreg(8'h18, 32'h11112222);
      wreg(8'h1C, 32'h33334444);
      wreg(8'h40, 32'h55556666);
      wreg(8'h44, 32'hDEADBEEF);
      rreg(8'h18, rv); chk("R11 pull enable", rv, 32'h11112222);
      rreg(8'h1C, rv); chk("R11 pull select", rv, 32'h33334444);
      rreg(8'h40, rv); chk("R11 filter enable", rv, 32'h55556666);
      rreg(8'h44, rv); chk("R11 filter divider", rv, 32'hDEADBEEF);

      // R12: unused, write-only and misaligned reads
      begin
         logic [7:0] zr [7] = '{8'h0C, 8'h28, 8'h48, 8'h10, 8'h14, 8'h30, 8'h01};
         for (int i = 0; i < 7; i++) begin
            rreg(zr[i], rv);
            chk($sformatf("R12 zero read %h", zr[i]), rv, 32'h0);
         end
         wreg(8'h0C, 32'hFFFFFFFF);
         rreg(8'h00, rv);
         chk("R12 unused write ignored", rv, 32'h05A5A5AE);
      end

      // vector table: R5, R6, R7
      wreg(8'h20, 32'hFFFFFFFF);
      wreg(8'h2C, 32'h0);
      for (int i = 0; i < 7; i++) begin
         wreg(8'h34, VT[i].kind);
         wreg(8'h3C, VT[i].pol);
         wreg(8'h38, VT[i].any);
         setpad(VT[i].pa);
         settle();
         wreg(8'h30, 32'hFFFFFFFF);
         settle();
         setpad(VT[i].pb);
         settle();
         rreg(8'h24, rv);
         chk($sformatf("R5/R6/R7 vector %0d status", i), rv, VT[i].exp);
         chk($sformatf("R10 vector %0d irq", i), {31'h0, irq}, {31'h0, (VT[i].exp != 0)});
      end

      // R9: enable gating, rising edges on all pins
      wreg(8'h34, 32'h0);
      wreg(8'h3C, 32'h0);
      wreg(8'h38, 32'h0);
      setpad(32'h0);
      settle();
      wreg(8'h30, 32'hFFFFFFFF);
      wreg(8'h20, 32'hFFFFFFFE);
      setpad(32'h00000001);
      settle();
      rreg(8'h24, rv);
      chk("R9 disabled pin hidden", rv, 32'h0);
      chk("R9 irq low while disabled", {31'h0, irq}, 32'h0);
      wreg(8'h20, 32'hFFFFFFFF);
      rreg(8'h24, rv);
      chk("R9 pending shows after enable", rv, 32'h00000001);

      // R10: mask
      wreg(8'h2C, 32'h00000001);
      chk("R10 masked irq", {31'h0, irq}, 32'h0);
      rreg(8'h24, rv);
      chk("R10 status unchanged by mask", rv, 32'h00000001);
      wreg(8'h2C, 32'h0);
      chk("R10 unmasked irq", {31'h0, irq}, 32'h1);

      // R8: per-bit acknowledge
      setpad(32'h00000003);
      settle();
      wreg(8'h30, 32'h00000001);
      rreg(8'h24, rv);
      chk("R8 single-bit ack", rv, 32'h00000002);

      // R8: edge in the same cycle as acknowledge keeps the bit
      wreg(8'h30, 32'hFFFFFFFF);
      wreg(8'h38, 32'h00000001);
      setpad(32'h00000002);           // falling edge on pin 0 sets pending
      settle();
      rreg(8'h24, rv);
      chk("R7 falling edge in any-edge mode", rv, 32'h00000001);
      setpad(32'h00000003);           // rising edge on pin 0
      @(negedge clk);
      wreg(8'h30, 32'h00000001);      // ack lands on the latch cycle
      rreg(8'h24, rv);
      chk("R8 edge beats same-cycle ack", rv, 32'h00000001);
      wreg(8'h30, 32'h00000001);
      rreg(8'h24, rv);
      chk("R8 plain ack clears", rv, 32'h0);

      // R5: level status cannot be acknowledged
      wreg(8'h34, 32'h00000001);
      wreg(8'h3C, 32'h0);
      settle();
      rreg(8'h24, rv);
      chk("R5 level high active", rv, 32'h00000001);
      wreg(8'h30, 32'h00000001);
      rreg(8'h24, rv);
      chk("R5 ack does not clear level", rv, 32'h00000001);
      setpad(32'h00000002);
      settle();
      rreg(8'h24, rv);
      chk("R5 level follows input low", rv, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule